// File: doc/BRIEF.md
# Vertical-Blanking Caption Data Inserter

This block places two caption or extended-data bytes per field onto one chosen line of the vertical blanking interval. Software loads a separate byte pair for each of the two fields through a small write-only register port. On the selected line, after a programmable number of samples past the horizontal reference, the block produces a burst of level codes in a fixed order. The burst opens with seven clock run-in cycles, follows with a three-bit start pattern, and ends with the sixteen data bits. The codes are meant to be added into the luma path downstream.

The bit clock is 32 times the line rate. It is built with a phase accumulator, so a line length in samples that is not a multiple of 32 still gives the correct average bit width. This holds for 525-line and 625-line timing alike. A low bit produces the blanking level code, which stands for 0 IRE. A high bit produces a code near 50 IRE. Outside the burst the output holds the blanking code.

A pair is marked pending when its upper byte is written. Starting transmission of the pair clears the mark. If a field's line comes up with nothing pending, the null pair 0x80, 0x80 is sent instead. An optional mode overwrites bit 7 of every byte with odd parity over bits 6..0.

Top module: `cc_line21_encoder`

## Requirements
- R1: After reset, `cc_level` equals LOW_CODE, `cc_active` is 0, `data_pending` is 2'b00, the line register holds 21, the start offset is 0 and parity generation is off.
- R2: Register map, addressed by `wr_addr` and loaded on the rising clock edge while `wr_en` is high. Address 0 is the first byte of field 0 and address 1 is its second byte. Addresses 2 and 3 are the first and second bytes of field 1. Address 4 is the line select, address 5 is the start offset, and bit 0 of address 6 is the parity enable. Writing address 1 or 3 sets `data_pending[0]` or `data_pending[1]` respectively. Writing the first byte alone does not set it.
- R3: The line select saturates into [LINE_MIN, LINE_MAX], 14 to 28 by default, when written. The line that carries both `line_sync` and `field_sync` is line 1, and each later `line_sync` adds one. The burst is sent only on the line whose number equals the line select.
- R4: If the edge that samples `line_sync` for the selected line is edge 0, then `cc_active` first reads high after edge start_offset+1.
- R5: The burst is 52 half-bits, each lasting LINE_LEN/64 clocks on average. Half-bits 0 to 13 alternate high and low, starting high. Then come the start bits 0, 0, 1, and then 16 data bits, each two half-bits long. The data bits go first byte first, least significant bit first.
- R6: While `cc_active` is high, `cc_level` is HIGH_CODE for a 1 bit and LOW_CODE for a 0 bit. While `cc_active` is low, it is LOW_CODE.
- R7: When the burst starts, the pending pair of that field is latched and its `data_pending` bit is cleared. With nothing pending, the null pair 0x80, 0x80 is sent.
- R8: With parity enabled, bit 7 of each byte sent is set so that the byte has an odd number of ones. With parity disabled, the bytes are sent as written.
- R9: The value of `field_odd` sampled with `field_sync` selects the pair for that field: 0 selects addresses 0 and 1, and 1 selects addresses 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| line_sync | input | 1 | One-cycle pulse at each horizontal reference |
| field_sync | input | 1 | Marks the first line of a field (valid with line_sync) |
| field_odd | input | 1 | Field identity, sampled with field_sync |
| cc_level | output | LVL_W | Level code to add into luma |
| cc_active | output | 1 | High during the insertion burst |
| data_pending | output | 2 | Per-field pending flags |

## Verification
The assertions check four properties on every cycle. Only the two level codes appear during a burst. The blanking code holds outside the burst. Every burst opens with a high half-bit and never exceeds its length bound. A pending flag falls only when a burst starts. The bench scenarios cover everything that depends on stored content or on counting lines: which line carries the burst, the exact start cycle, the bit order, parity, the null pair and the choice of field.

// File: rtl/cc_pkg.sv
// Shared constants and helpers for the caption line inserter.
// Assumes a 52 half-bit burst: 14 run-in halves, 6 start-bit halves, 32 data halves.
package cc_pkg;
    localparam int HALF_BITS    = 52;
    localparam int RUNIN_HALVES = 14;
    localparam int START_END    = 20;   // first data half-bit index
    localparam int HALF_STEP    = 64;   // half-bits per line
    localparam logic [7:0] NULL_BYTE = 8'h80;

    typedef enum logic [2:0] {
        A_F0_LO = 3'd0,
        A_F0_HI = 3'd1,
        A_F1_LO = 3'd2,
        A_F1_HI = 3'd3,
        A_LINE  = 3'd4,
        A_OFS   = 3'd5,
        A_CTRL  = 3'd6
    } reg_addr_e;

    // Replace bit 7 so that the byte carries an odd count of ones.
    function automatic logic [7:0] odd_fix(input logic [7:0] b);
        return {~^b[6:0], b[6:0]};
    endfunction
endpackage

// File: rtl/cc_regs.sv
// Register file: per-field byte pairs with pending flags, line select
// (clamped on write), start offset and parity enable. Supplies the word
// to send for the field being served; assumes take_i is a one-cycle pulse.
module cc_regs #(
    parameter int LINE_W       = 5,
    parameter int DEFAULT_LINE = 21,
    parameter int LINE_MIN     = 14,
    parameter int LINE_MAX     = 28,
    parameter int DEFAULT_OFS  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              take_i,
    input  logic              take_field_i,
    output logic [15:0]       word_o,
    output logic [LINE_W-1:0] line_sel_o,
    output logic [7:0]        ofs_o,
    output logic [1:0]        pend_o
);
    import cc_pkg::*;

    logic [15:0] pair [2];
    logic        par_en_q;
    logic [15:0] raw_w;
    logic [15:0] sel_w;

    for (genvar f = 0; f < 2; f++) begin : g_field
        logic [7:0] lo_q;
        logic [7:0] hi_q;
        logic       pend_q;

        // Byte storage and pending flag for one field.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q   <= '0;
                hi_q   <= '0;
                pend_q <= 1'b0;
            end else begin
                if (wr_en && wr_addr == 3'(2*f))
                    lo_q <= wr_data;
                if (wr_en && wr_addr == 3'(2*f+1)) begin
                    hi_q   <= wr_data;
                    pend_q <= 1'b1;
                end else if (take_i && take_field_i == 1'(f)) begin
                    pend_q <= 1'b0;
                end
            end
        end

        assign pair[f]   = {hi_q, lo_q};
        assign pend_o[f] = pend_q;
    end

    // Configuration registers; the line select saturates into its legal range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_sel_o <= LINE_W'(DEFAULT_LINE);
            ofs_o      <= 8'(DEFAULT_OFS);
            par_en_q   <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_LINE: begin
                    if (int'(wr_data) < LINE_MIN)
                        line_sel_o <= LINE_W'(LINE_MIN);
                    else if (int'(wr_data) > LINE_MAX)
                        line_sel_o <= LINE_W'(LINE_MAX);
                    else
                        line_sel_o <= LINE_W'(wr_data);
                end
                A_OFS:   ofs_o    <= wr_data;
                A_CTRL:  par_en_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Word for the served field: pending pair or null pair, parity applied.
    always_comb begin
        raw_w  = take_field_i ? pair[1] : pair[0];
        sel_w  = pend_o[take_field_i] ? raw_w : {NULL_BYTE, NULL_BYTE};
        word_o = par_en_q ? {odd_fix(sel_w[15:8]), odd_fix(sel_w[7:0])} : sel_w;
    end
endmodule

// File: rtl/cc_line_timer.sv
// Line and sample counting: numbers lines from the field marker, arms on
// the selected line and fires a one-cycle start pulse at the programmed
// sample offset. Assumes field_sync is only meaningful together with line_sync.
module cc_line_timer #(
    parameter int LINE_W   = 5,
    parameter int LINE_LEN = 1716
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_sync,
    input  logic              field_sync,
    input  logic              field_odd,
    input  logic [LINE_W-1:0] line_sel,
    input  logic [7:0]        ofs,
    input  logic              busy,
    output logic              start_o,
    output logic              field_o
);
    localparam int CNT_W = LINE_W + 1;
    localparam int POS_W = $clog2(LINE_LEN + 1);
    localparam int CMP_W = POS_W + 8;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [POS_W-1:0] pos_q;
    logic             armed_q;

    // Next line number: restart at 1 on a field marker, else count and saturate.
    always_comb begin
        if (field_sync)
            cnt_next = CNT_W'(1);
        else if (cnt_q == {CNT_W{1'b1}})
            cnt_next = cnt_q;
        else
            cnt_next = cnt_q + 1'b1;
    end

    assign start_o = armed_q && !busy && (CMP_W'(pos_q) == CMP_W'(ofs));

    // Line counter, sample position, arming and field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pos_q   <= '0;
            armed_q <= 1'b0;
            field_o <= 1'b0;
        end else if (line_sync) begin
            cnt_q   <= cnt_next;
            pos_q   <= '0;
            armed_q <= (cnt_next == {1'b0, line_sel});
            if (field_sync)
                field_o <= field_odd;
        end else begin
            if (pos_q != {POS_W{1'b1}})
                pos_q <= pos_q + 1'b1;
            if (start_o)
                armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cc_bit_seq.sv
// Burst sequencer: a phase accumulator yields 64 half-bit ticks per line,
// a half-bit index walks run-in, start bits and data, and the level code
// follows the current bit. Assumes LINE_LEN >= 64.
module cc_bit_seq #(
    parameter int                LINE_LEN  = 1716,
    parameter int                LVL_W     = 10,
    parameter logic [LVL_W-1:0]  LOW_CODE  = 10'd240,
    parameter logic [LVL_W-1:0]  HIGH_CODE = 10'd480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      word_i,
    output logic             busy_o,
    output logic [LVL_W-1:0] level_o
);
    import cc_pkg::*;

    localparam int ACC_W = $clog2(LINE_LEN) + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum_w;
    logic             tick_w;
    logic [5:0]       half_q;
    logic [15:0]      word_q;
    logic [5:0]       data_half_w;
    logic             bit_w;

    assign sum_w  = acc_q + ACC_W'(HALF_STEP);
    assign tick_w = (sum_w >= ACC_W'(LINE_LEN));
    assign data_half_w = half_q - 6'(START_END);

    // Phase accumulator, half-bit index and latched data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            acc_q  <= '0;
            half_q <= '0;
            word_q <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            acc_q  <= '0;
            half_q <= '0;
            word_q <= word_i;
        end else if (busy_o) begin
            acc_q <= tick_w ? (sum_w - ACC_W'(LINE_LEN)) : sum_w;
            if (tick_w) begin
                if (half_q == 6'(HALF_BITS - 1))
                    busy_o <= 1'b0;
                else
                    half_q <= half_q + 1'b1;
            end
        end
    end

    // Bit value for the current half-bit: run-in, start pattern or data.
    always_comb begin
        if (half_q < 6'(RUNIN_HALVES))
            bit_w = ~half_q[0];
        else if (half_q < 6'(START_END))
            bit_w = (half_q >= 6'(START_END - 2));
        else
            bit_w = word_q[data_half_w[4:1]];
    end

    assign level_o = (busy_o && bit_w) ? HIGH_CODE : LOW_CODE;
endmodule

// File: rtl/cc_line21_encoder.sv
// Top of the caption line inserter: joins register file, line timer and
// burst sequencer. Assumes line_sync pulses once per line for one cycle.
module cc_line21_encoder #(
    parameter int                LINE_LEN     = 1716,
    parameter int                LVL_W        = 10,
    parameter logic [LVL_W-1:0]  LOW_CODE     = 10'd240,
    parameter logic [LVL_W-1:0]  HIGH_CODE    = 10'd480,
    parameter int                DEFAULT_LINE = 21,
    parameter int                LINE_MIN     = 14,
    parameter int                LINE_MAX     = 28,
    parameter int                DEFAULT_OFS  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             line_sync,
    input  logic             field_sync,
    input  logic             field_odd,
    output logic [LVL_W-1:0] cc_level,
    output logic             cc_active,
    output logic [1:0]       data_pending
);
    localparam int LINE_W = $clog2(LINE_MAX + 1);

    logic              start_w;
    logic              field_w;
    logic              busy_w;
    logic [15:0]       word_w;
    logic [LINE_W-1:0] line_sel_w;
    logic [7:0]        ofs_w;

    cc_regs #(
        .LINE_W(LINE_W), .DEFAULT_LINE(DEFAULT_LINE),
        .LINE_MIN(LINE_MIN), .LINE_MAX(LINE_MAX), .DEFAULT_OFS(DEFAULT_OFS)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .take_i(start_w), .take_field_i(field_w),
        .word_o(word_w), .line_sel_o(line_sel_w), .ofs_o(ofs_w),
        .pend_o(data_pending)
    );

    cc_line_timer #(
        .LINE_W(LINE_W), .LINE_LEN(LINE_LEN)
    ) i_timer (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync),
        .field_sync(field_sync), .field_odd(field_odd),
        .line_sel(line_sel_w), .ofs(ofs_w), .busy(busy_w),
        .start_o(start_w), .field_o(field_w)
    );

    cc_bit_seq #(
        .LINE_LEN(LINE_LEN), .LVL_W(LVL_W),
        .LOW_CODE(LOW_CODE), .HIGH_CODE(HIGH_CODE)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_w), .word_i(word_w),
        .busy_o(busy_w), .level_o(cc_level)
    );

    assign cc_active = busy_w;
endmodule

// File: rtl/cc_line21_checker.sv
// Protocol checker for the caption inserter, bound to the top module.
// Assumes the parameters match those of the bound instance.
module cc_line21_checker #(
    parameter int               LINE_LEN  = 1716,
    parameter int               LVL_W     = 10,
    parameter logic [LVL_W-1:0] LOW_CODE  = 10'd240,
    parameter logic [LVL_W-1:0] HIGH_CODE = 10'd480
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] cc_level,
    input logic             cc_active,
    input logic [1:0]       data_pending
);
    localparam int MAX_ACT = cc_pkg::HALF_BITS * ((LINE_LEN + 63) / 64);

    int act_cnt;

    // Count cycles of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)        act_cnt <= 0;
        else if (cc_active) act_cnt <= act_cnt + 1;
        else               act_cnt <= 0;
    end

    p_idle_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_active |-> cc_level == LOW_CODE);
    p_two_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cc_active |-> (cc_level == LOW_CODE || cc_level == HIGH_CODE));
    p_runin_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_active) |-> cc_level == HIGH_CODE);
    p_burst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cc_active |-> act_cnt < MAX_ACT);
    p_clear_f0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_pending[0]) |-> $rose(cc_active));
    p_clear_f1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_pending[1]) |-> $rose(cc_active));
endmodule

bind cc_line21_encoder cc_line21_checker #(
    .LINE_LEN(LINE_LEN), .LVL_W(LVL_W),
    .LOW_CODE(LOW_CODE), .HIGH_CODE(HIGH_CODE)
) i_checker (
    .clk(clk), .rst_n(rst_n), .cc_level(cc_level),
    .cc_active(cc_active), .data_pending(data_pending)
);

// File: tb/test_cc_line21_encoder.sv
module test_cc_line21_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int LEN   = 128;
    localparam int NLINE = 32;
    localparam logic [9:0] LO = 10'd240;
    localparam logic [9:0] HI = 10'd480;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       line_sync = 1'b0;
    logic       field_sync = 1'b0;
    logic       field_odd = 1'b0;
    logic [9:0] cc_level;
    logic       cc_active;
    logic [1:0] data_pending;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int cur_line = 0;
    int ls_cyc = 0;
    logic prev_act = 1'b0;
    logic [9:0] exp_q[$];
    int exp_line_q[$];
    int exp_ofs_q[$];

    cc_line21_encoder #(.LINE_LEN(LEN), .LOW_CODE(LO), .HIGH_CODE(HI)) i_cc_line21_encoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_sync(line_sync), .field_sync(field_sync),
        .field_odd(field_odd), .cc_level(cc_level), .cc_active(cc_active),
        .data_pending(data_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] par(input logic [7:0] b);
        return {~^b[6:0], b[6:0]};
    endfunction

    // Driver side: queue the expected burst (R5 order, 2 clocks per half-bit).
    task automatic expect_burst(input logic [15:0] w, input int line, input int ofs);
        for (int h = 0; h < 52; h++) begin
            bit b;
            if (h < 14)      b = (h % 2 == 0);
            else if (h < 20) b = (h >= 18);
            else             b = w[(h - 20) / 2];
            exp_q.push_back(b ? HI : LO);
            exp_q.push_back(b ? HI : LO);
        end
        exp_line_q.push_back(line);
        exp_ofs_q.push_back(ofs);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_field(input bit odd);
        for (int l = 1; l <= NLINE; l++) begin
            @(negedge clk);
            line_sync = 1'b1; field_sync = (l == 1); field_odd = odd;
            cur_line = l; ls_cyc = cyc + 1;
            @(negedge clk);
            line_sync = 1'b0; field_sync = 1'b0;
            repeat (LEN - 2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && exp_line_q.size() == 0, "R3 burst sent on expected line",
              exp_q.size(), 0);
    endtask

    // Monitor side: pop and compare on every active cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cc_active) begin
                if (!prev_act) begin
                    if (exp_line_q.size() == 0) begin
                        check(1'b0, "R3 unexpected burst", cur_line, 0);
                    end else begin
                        int el, eo;
                        el = exp_line_q.pop_front();
                        eo = exp_ofs_q.pop_front();
                        check(cur_line == el, "R3 burst line", cur_line, el);
                        check(cyc == ls_cyc + eo + 1, "R4 burst start cycle", cyc - ls_cyc, eo + 1);
                    end
                end
                if (exp_q.size() == 0) check(1'b0, "R5 extra burst sample", cc_level, 0);
                else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check(cc_level == e, "R5 R6 burst level", cc_level, e);
                end
            end else if (cc_level != LO) begin
                check(1'b0, "R6 idle level", cc_level, LO);
            end
            prev_act <= cc_active;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog expired", 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cc_level == LO, "R1 reset level", cc_level, LO);
        check(cc_active == 1'b0, "R1 reset active", cc_active, 0);
        check(data_pending == 2'b00, "R1 reset pending", data_pending, 0);

        // R1 default line 21, offset 0; R7 null pair with nothing pending
        expect_burst(16'h8080, 21, 0);
        run_field(1'b0);

        // R2 writes, R4 offset, R5 bit order
        wr(3'd5, 8'd12);
        wr(3'd0, 8'h41);
        check(data_pending == 2'b00, "R2 first byte alone not pending", data_pending, 0);
        wr(3'd1, 8'hC2);
        @(negedge clk);
        check(data_pending == 2'b01, "R2 pending set field0", data_pending, 1);
        expect_burst(16'hC241, 21, 12);
        run_field(1'b0);
        check(data_pending == 2'b00, "R7 pending cleared", data_pending, 0);

        // R8 parity, R9 field select, R3 line move
        wr(3'd6, 8'h01);
        wr(3'd2, 8'h14);
        wr(3'd3, 8'h57);
        wr(3'd4, 8'd15);
        @(negedge clk);
        check(data_pending == 2'b10, "R2 pending set field1", data_pending, 2);
        expect_burst(16'h8080, 15, 12);
        run_field(1'b0);
        check(data_pending == 2'b10, "R9 field0 leaves field1 pair", data_pending, 2);
        expect_burst({par(8'h57), par(8'h14)}, 15, 12);
        run_field(1'b1);
        check(data_pending == 2'b00, "R7 field1 cleared", data_pending, 0);

        // R3 clamp low, R8 parity on other bytes
        wr(3'd4, 8'd3);
        wr(3'd5, 8'd20);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'h00);
        expect_burst({par(8'h00), par(8'hFF)}, 14, 20);
        run_field(1'b0);

        // R3 clamp high, R8 off, R7 null when only first byte written
        wr(3'd4, 8'd40);
        wr(3'd6, 8'h00);
        wr(3'd2, 8'h03);
        expect_burst(16'h8080, 28, 20);
        run_field(1'b1);

        // R8 off: bytes sent as written
        wr(3'd2, 8'h03);
        wr(3'd3, 8'h01);
        expect_burst(16'h0103, 28, 20);
        run_field(1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule